// File: doc/BRIEF.md
# Dual-Mode Hysteretic PWM Generator

This block turns a 16-bit duty setpoint into a single pulse-width modulated pin. It has two modes. For large setpoints it runs a fast PWM with a 256-clock period. The setpoint is scaled to an 8-bit compare value, and that value is capped by a percent limit input. For small setpoints it switches to a slow high-resolution PWM with a 65536-clock period. In that mode the setpoint itself is the number of active clocks, which gives fine control near zero duty.

The mode is chosen each time a new setpoint is strobed in. A threshold with a hysteresis band around it keeps a setpoint that hovers near the boundary from toggling the mode. A critical-fault input shuts the generator down at once. An invert input selects the pin polarity, and the idle level follows the same polarity.

Top module: `pwm_dual_mode_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `mode_o` is 0 (no mode established) and `pwm_o` equals the idle level, which is the value of `inv_i`.
- R2: A strobed setpoint above 0x0BFF, or a strobed setpoint of exactly 0, gives `mode_o` = 1 (fast) on the cycle after the strobe.
- R3: A strobed setpoint from 0x0001 to 0x07FF gives `mode_o` = 2 (high resolution) on the next cycle. A setpoint from 0x0800 to 0x0BFF does the same when `mode_o` is 0.
- R4: A strobed setpoint from 0x0800 to 0x0BFF leaves a `mode_o` of 1 or 2 unchanged.
- R5: In fast mode, each 256-clock period has exactly D active clocks. D = floor(sp × P / 65535) and P = floor(255 × min(pct, 100) / 100), where sp and pct are the values taken at the strobe.
- R6: In high-resolution mode, each 65536-clock period has exactly sp active clocks.
- R7: In fast mode, a computed D of 0 keeps the pin at the idle level on every cycle.
- R8: A strobe that changes the mode restarts the period at once: the pin is active on the second cycle after the strobe. A strobe that keeps the mode takes effect only at the next period boundary, so the period already running finishes with the old value.
- R9: An asserted `fault_i` takes priority over a strobe. On the next cycle, and until the next accepted strobe, `mode_o` is 0 and `pwm_o` is at the idle level.
- R10: `pwm_o` is the internal active level XOR `inv_i`, and it is registered one cycle after the state it reflects.
- R11: A change on `sp_i` while `sp_vld_i` is low has no effect on the mode or on the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sp_i | input | 16 | Duty setpoint |
| sp_vld_i | input | 1 | Setpoint strobe, one cycle |
| inv_i | input | 1 | Output polarity; 1 inverts the pin and makes the idle level high |
| lim_pct_i | input | 7 | Fast-mode duty ceiling in percent; values above 100 are treated as 100 |
| fault_i | input | 1 | Critical-fault shutdown |
| pwm_o | output | 1 | PWM pin |
| mode_o | output | 2 | 0 = none, 1 = fast, 2 = high resolution |

## Verification
The assertions check the mode-selection rules on every cycle: the fast and high-resolution thresholds, holding the mode inside the band, leaving the mode alone when there is no strobe, and returning to idle after a fault or while no mode is set. The pulse widths cannot be shown by a single-cycle property. These are the scaled duty with the percent limit, the 65536-clock high-resolution period, the boundary-deferred update that prevents runt pulses and the immediate restart on a mode change. The bench covers them by comparing against its reference model on every clock and by counting active cycles over whole periods.

// File: rtl/pwm_dual_pkg.sv
`timescale 1ns/1ps
package pwm_dual_pkg;
  typedef enum logic [1:0] {
    MODE_NONE  = 2'd0,
    MODE_FAST  = 2'd1,
    MODE_HIRES = 2'd2
  } pwm_mode_e;
endpackage

// File: rtl/pwm_mode_sel.sv
`timescale 1ns/1ps
module pwm_mode_sel
  import pwm_dual_pkg::*;
#(
  parameter int SP_W   = 16,
  parameter int THRESH = 'h9FF,
  parameter int HYST   = 'h200
) (
  input  logic [SP_W-1:0] sp,
  input  pwm_mode_e       cur_mode,
  output pwm_mode_e       nxt_mode
);
  localparam logic [SP_W-1:0] UPPER = SP_W'(THRESH + HYST);
  localparam logic [SP_W-1:0] LOWER = SP_W'(THRESH - HYST);

  always_comb begin
    nxt_mode = cur_mode;
    if (sp > UPPER || sp == '0)
      nxt_mode = MODE_FAST;
    else if (sp <= LOWER || cur_mode == MODE_NONE)
      nxt_mode = MODE_HIRES;
  end
endmodule

// File: rtl/pwm_duty_scale.sv
`timescale 1ns/1ps
module pwm_duty_scale #(
  parameter int SP_W   = 16,
  parameter int FAST_W = 8,
  parameter int PCT_W  = 7
) (
  input  logic [SP_W-1:0]   sp,
  input  logic [PCT_W-1:0]  pct,
  output logic [FAST_W-1:0] duty
);
  localparam int LIM_W  = FAST_W + PCT_W;
  localparam int PROD_W = SP_W + FAST_W;
  localparam logic [LIM_W-1:0]  FAST_MAX = LIM_W'((1 << FAST_W) - 1);
  localparam logic [PROD_W-1:0] SP_MAX   = PROD_W'((1 << SP_W) - 1);

  logic [PCT_W-1:0]  pct_c;
  logic [FAST_W-1:0] pos_lim;
  logic [PROD_W-1:0] prod;

  always_comb begin
    pct_c   = (pct > PCT_W'(100)) ? PCT_W'(100) : pct;
    pos_lim = FAST_W'((FAST_MAX * LIM_W'(pct_c)) / LIM_W'(100));
    prod    = PROD_W'(sp) * PROD_W'(pos_lim);
    duty    = FAST_W'(prod / SP_MAX);
  end
endmodule

// File: rtl/pwm_timebase_core.sv
`timescale 1ns/1ps
module pwm_timebase_core
  import pwm_dual_pkg::*;
#(
  parameter int SP_W   = 16,
  parameter int FAST_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fault,
  input  logic            load,
  input  logic            restart,
  input  pwm_mode_e       new_mode,
  input  logic [SP_W-1:0] new_cmp,
  input  logic            inv,
  output pwm_mode_e       mode_q,
  output logic            pwm_q
);
  logic [SP_W-1:0] cnt_q;
  logic [SP_W-1:0] cmp_q;
  logic [SP_W-1:0] pend_q;
  logic            wrap;
  logic            active;
  logic            fast_zero;

  always_comb begin
    fast_zero = (cmp_q[FAST_W-1:0] == '0);
    wrap      = 1'b0;
    active    = 1'b0;
    case (mode_q)
      MODE_FAST: begin
        wrap   = (cnt_q[FAST_W-1:0] == '1);
        active = !fast_zero && (cnt_q[FAST_W-1:0] < cmp_q[FAST_W-1:0]);
      end
      MODE_HIRES: begin
        wrap   = (cnt_q == '1);
        active = (cnt_q < cmp_q);
      end
      default: begin
        wrap   = 1'b0;
        active = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || fault) begin
      mode_q <= MODE_NONE;
      cnt_q  <= '0;
      cmp_q  <= '0;
      pend_q <= '0;
      pwm_q  <= inv;
    end else begin
      pwm_q <= active ^ inv;
      if (load)
        pend_q <= new_cmp;
      if (restart) begin
        mode_q <= new_mode;
        cnt_q  <= '0;
        cmp_q  <= new_cmp;
      end else begin
        if (mode_q != MODE_NONE)
          cnt_q <= cnt_q + 1'b1;
        if (wrap)
          cmp_q <= pend_q;
      end
    end
  end
endmodule

// File: rtl/pwm_dual_mode_gen.sv
`timescale 1ns/1ps
module pwm_dual_mode_gen
  import pwm_dual_pkg::*;
#(
  parameter int SP_W   = 16,
  parameter int FAST_W = 8,
  parameter int PCT_W  = 7,
  parameter int THRESH = 'h9FF,
  parameter int HYST   = 'h200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SP_W-1:0]  sp_i,
  input  logic             sp_vld_i,
  input  logic             inv_i,
  input  logic [PCT_W-1:0] lim_pct_i,
  input  logic             fault_i,
  output logic             pwm_o,
  output logic [1:0]       mode_o
);
  pwm_mode_e         cur_mode;
  pwm_mode_e         nxt_mode;
  logic [FAST_W-1:0] duty;
  logic [SP_W-1:0]   cmp_val;
  logic              accept;
  logic              restart;

  pwm_mode_sel #(.SP_W(SP_W), .THRESH(THRESH), .HYST(HYST)) u_sel (
    .sp       (sp_i),
    .cur_mode (cur_mode),
    .nxt_mode (nxt_mode)
  );

  pwm_duty_scale #(.SP_W(SP_W), .FAST_W(FAST_W), .PCT_W(PCT_W)) u_scale (
    .sp   (sp_i),
    .pct  (lim_pct_i),
    .duty (duty)
  );

  always_comb begin
    accept  = sp_vld_i && !fault_i;
    restart = accept && (nxt_mode != cur_mode);
    cmp_val = (nxt_mode == MODE_FAST) ? SP_W'(duty) : sp_i;
  end

  pwm_timebase_core #(.SP_W(SP_W), .FAST_W(FAST_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .fault    (fault_i),
    .load     (accept),
    .restart  (restart),
    .new_mode (nxt_mode),
    .new_cmp  (cmp_val),
    .inv      (inv_i),
    .mode_q   (cur_mode),
    .pwm_q    (pwm_o)
  );

  assign mode_o = cur_mode;
endmodule

// File: rtl/pwm_dual_mode_chk.sv
`timescale 1ns/1ps
module pwm_dual_mode_chk #(
  parameter int SP_W   = 16,
  parameter int THRESH = 'h9FF,
  parameter int HYST   = 'h200
) (
  input logic            clk,
  input logic            rst,
  input logic [SP_W-1:0] sp_i,
  input logic            sp_vld_i,
  input logic            inv_i,
  input logic            fault_i,
  input logic            pwm_o,
  input logic [1:0]      mode_o
);
  localparam logic [SP_W-1:0] UPPER = SP_W'(THRESH + HYST);
  localparam logic [SP_W-1:0] LOWER = SP_W'(THRESH - HYST);

  logic acc;
  logic in_band;
  assign acc     = sp_vld_i && !fault_i;
  assign in_band = (sp_i > LOWER) && (sp_i <= UPPER);

  a_r2_fast_select: assert property (@(posedge clk) disable iff (rst)
    acc && (sp_i > UPPER || sp_i == '0) |=> mode_o == 2'd1);

  a_r3_hires_select: assert property (@(posedge clk) disable iff (rst)
    acc && sp_i != '0 && sp_i <= LOWER |=> mode_o == 2'd2);

  a_r3_band_from_none: assert property (@(posedge clk) disable iff (rst)
    acc && in_band && mode_o == 2'd0 |=> mode_o == 2'd2);

  a_r4_band_holds: assert property (@(posedge clk) disable iff (rst)
    acc && in_band && mode_o != 2'd0 |=> $stable(mode_o));

  a_r11_no_strobe_stable: assert property (@(posedge clk) disable iff (rst)
    !sp_vld_i && !fault_i |=> $stable(mode_o));

  a_r9_fault_idle: assert property (@(posedge clk) disable iff (rst)
    fault_i |=> mode_o == 2'd0 && pwm_o == $past(inv_i));

  a_r9_none_idle: assert property (@(posedge clk) disable iff (rst)
    mode_o == 2'd0 |=> pwm_o == $past(inv_i));
endmodule

bind pwm_dual_mode_gen pwm_dual_mode_chk #(
  .SP_W(SP_W), .THRESH(THRESH), .HYST(HYST)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sp_i     (sp_i),
  .sp_vld_i (sp_vld_i),
  .inv_i    (inv_i),
  .fault_i  (fault_i),
  .pwm_o    (pwm_o),
  .mode_o   (mode_o)
);

// File: tb/pwm_dual_mode_gen_bench.sv
`timescale 1ns/1ps
module pwm_dual_mode_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sp_i = '0;
  logic        sp_vld_i = 1'b0;
  logic        inv_i = 1'b0;
  logic [6:0]  lim_pct_i = 7'd100;
  logic        fault_i = 1'b0;
  logic        pwm_o;
  logic [1:0]  mode_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dual_mode_gen u_pwm_dual_mode_gen (
    .clk(clk), .rst(rst), .sp_i(sp_i), .sp_vld_i(sp_vld_i), .inv_i(inv_i),
    .lim_pct_i(lim_pct_i), .fault_i(fault_i), .pwm_o(pwm_o), .mode_o(mode_o)
  );

  // reference model state
  int m_mode = 0;
  int m_cnt = 0;
  int m_cmp = 0;
  int m_pend = 0;
  int m_pwm = 0;

  function automatic int scale(int sp, int pct);
    int p;
    p = (pct > 100) ? 100 : pct;
    return (sp * ((255 * p) / 100)) / 65535;
  endfunction

  function automatic int pick(int sp, int cur);
    if (sp > 'hBFF || sp == 0) return 1;
    if (sp <= 'h7FF || cur == 0) return 2;
    return cur;
  endfunction

  always @(posedge clk) begin
    int act, nm, v, wrap;
    if (rst || fault_i) begin
      m_mode = 0; m_cnt = 0; m_cmp = 0; m_pend = 0; m_pwm = int'(inv_i);
    end else begin
      if (m_mode == 1) act = (m_cmp != 0 && (m_cnt % 256) < m_cmp) ? 1 : 0;
      else if (m_mode == 2) act = (m_cnt < m_cmp) ? 1 : 0;
      else act = 0;
      wrap = ((m_mode == 1 && m_cnt % 256 == 255) || (m_mode == 2 && m_cnt == 65535)) ? 1 : 0;
      if (sp_vld_i) begin
        nm = pick(int'(sp_i), m_mode);
        v = (nm == 1) ? scale(int'(sp_i), int'(lim_pct_i)) : int'(sp_i);
        if (nm != m_mode) begin
          m_mode = nm; m_cnt = 0; m_cmp = v; m_pend = v;
        end else begin
          if (wrap != 0) m_cmp = m_pend;
          m_pend = v;
          m_cnt = (m_cnt + 1) % 65536;
        end
      end else begin
        if (m_mode != 0) m_cnt = (m_cnt + 1) % 65536;
        if (wrap != 0) m_cmp = m_pend;
      end
      m_pwm = act ^ int'(inv_i);
    end
  end

  // per-cycle comparison against the model (R5 R6 R7 R8 R10)
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_run++;
      if (int'(pwm_o) != m_pwm || int'(mode_o) != m_mode) begin
        n_fail++;
        $display("FAIL R5 R6 R7 R8 R10 cycle %0d: pwm=%0d mode=%0d expected pwm=%0d mode=%0d",
                 cyc, pwm_o, mode_o, m_pwm, m_mode);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d, expected end before 190000", cyc);
      finish_run();
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(int sp);
    sp_i = 16'(sp);
    sp_vld_i = 1'b1;
    @(negedge clk);
    sp_vld_i = 1'b0;
  endtask

  task automatic count_high(int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_o) hi++;
    end
  endtask

  initial begin
    int hi;
    int d;
    step(4);
    chk(pwm_o == 1'b0 && mode_o == 2'd0, "R1 during reset", int'(mode_o), 0);
    rst = 1'b0;
    step(1);
    chk(mode_o == 2'd0, "R1 mode after reset", int'(mode_o), 0);
    chk(pwm_o == inv_i, "R1 idle after reset", int'(pwm_o), int'(inv_i));

    // fast mode, full limit
    strobe('h4000);
    chk(mode_o == 2'd1, "R2 large setpoint selects fast", int'(mode_o), 1);
    step(300); count_high(256, hi);
    d = scale('h4000, 100);
    chk(hi == d, "R5 fast duty 0x4000", hi, d);

    // band keeps fast
    strobe('h0900);
    chk(mode_o == 2'd1, "R4 band keeps fast", int'(mode_o), 1);
    step(300); count_high(256, hi);
    d = scale('h0900, 100);
    chk(hi == d, "R5 fast duty 0x0900", hi, d);

    // high resolution
    strobe('h0100);
    chk(mode_o == 2'd2, "R3 small setpoint selects hires", int'(mode_o), 2);
    step(10); count_high(65536, hi);
    chk(hi == 'h100, "R6 hires active clocks", hi, 'h100);
    strobe('h0A00);
    chk(mode_o == 2'd2, "R4 band keeps hires", int'(mode_o), 2);

    // setpoint change without strobe
    sp_i = 16'hFFFF;
    step(20);
    chk(mode_o == 2'd2, "R11 unstrobed setpoint ignored", int'(mode_o), 2);

    // zero setpoint
    strobe(0);
    chk(mode_o == 2'd1, "R2 zero selects fast", int'(mode_o), 1);
    step(300); count_high(256, hi);
    chk(hi == 0, "R7 zero duty stays idle", hi, 0);

    // percent limit
    lim_pct_i = 7'd50;
    strobe('hFFFF);
    step(300); count_high(256, hi);
    d = scale('hFFFF, 50);
    chk(hi == d, "R5 limited duty", hi, d);

    // inversion
    inv_i = 1'b1;
    step(300); count_high(256, hi);
    chk(hi == 256 - d, "R10 inverted duty", hi, 256 - d);

    // fault
    fault_i = 1'b1;
    step(1);
    chk(mode_o == 2'd0, "R9 fault clears mode", int'(mode_o), 0);
    chk(pwm_o == 1'b1, "R9 fault idle inverted", int'(pwm_o), 1);
    step(3);
    fault_i = 1'b0;
    step(300); count_high(256, hi);
    chk(hi == 256 && mode_o == 2'd0, "R9 stays idle after fault", hi, 256);

    // band from no mode
    strobe('h0900);
    chk(mode_o == 2'd2, "R3 band from none selects hires", int'(mode_o), 2);

    // fault beats strobe
    fault_i = 1'b1;
    strobe('h4000);
    fault_i = 1'b0;
    chk(mode_o == 2'd0, "R9 fault has priority over strobe", int'(mode_o), 0);

    // restart on mode change and boundary-deferred update
    inv_i = 1'b0;
    lim_pct_i = 7'd100;
    step(2);
    strobe('h8000);
    step(1);
    chk(pwm_o == 1'b1, "R8 restart active on second cycle", int'(pwm_o), 1);
    step(48);
    strobe('h1000);
    step(51);
    chk(pwm_o == 1'b1, "R8 running period keeps old duty", int'(pwm_o), 1);
    step(300); count_high(256, hi);
    d = scale('h1000, 100);
    chk(hi == d, "R8 new duty after boundary", hi, d);

    finish_run();
  end
endmodule